// File: doc/BRIEF.md
# Pseudo-Instruction Micro-Op Expander

This block sits in the front end of a 32-register RISC core whose register 0 always reads as zero and whose register 1 is reserved as a scratch register for assembler sequences. It takes one instruction per cycle over a valid/ready handshake and rewrites convenience forms (copy, bitwise invert, unconditional jump and the four signed compare-and-branch forms) into base micro-ops that use the zero register as an operand. Base opcodes pass through untouched.

A compare-and-branch becomes a pair of micro-ops: a signed set-less-than that writes the scratch register, then a branch that tests the scratch register against zero. The pair leaves in order on a registered valid/ready output, and each micro-op is tagged with a flag that marks the final op of its expansion. The input stalls until the pair has drained, so nothing can come between its two ops.

Top module: `pxp_expander`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Opcodes 0 to 7 and 15 are base ops. They leave as one micro-op with opcode, `dst`=rd, `src_a`=rs, `src_b`=rt and offset copied unchanged, and `out_last`=1.
- R3: Opcode 8 (copy) leaves as one ADD (opcode 0) with `dst`=rd, `src_a`=rs, `src_b`=0, offset 0 and `out_last`=1.
- R4: Opcode 9 (invert) leaves as one NOR (opcode 1) with `dst`=rd, `src_a`=rs, `src_b`=0, offset 0 and `out_last`=1.
- R5: Opcode 10 (jump) leaves as one BEQ (opcode 3) with `dst`, `src_a` and `src_b` all 0, the input offset kept, and `out_last`=1.
- R6: Opcodes 11 (greater) and 12 (less) leave as SLT (opcode 2) into register 1 with sources (rt, rs) for 11 and (rs, rt) for 12. This is followed by BNE (opcode 4) with `dst`=0, `src_a`=1 and `src_b`=0.
- R7: Opcodes 13 (greater-or-equal) and 14 (less-or-equal) leave as SLT into register 1 with sources (rs, rt) for 13 and (rt, rs) for 14. This is followed by BEQ with `dst`=0, `src_a`=1 and `src_b`=0.
- R8: In a two-op expansion the first op has `out_last`=0 and offset 0. The branch op has `out_last`=1 and carries the input offset.
- R9: While the first op of a pair is on the output, `in_ready` is 0. The second op is the very next micro-op to leave, ahead of any later instruction.
- R10: While `out_valid`=1 and `out_ready`=0, every output field holds its value into the next cycle.
- R11: An instruction accepted at a clock edge has its first micro-op on the output in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Expander can take an instruction |
| in_opc | input | 4 | Instruction opcode |
| in_rd | input | REG_W | Destination field |
| in_rs | input | REG_W | First source field |
| in_rt | input | REG_W | Second source field |
| in_off | input | OFF_W | Branch offset |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_opc | output | 4 | Micro-op opcode |
| out_dst | output | REG_W | Micro-op destination register |
| out_src_a | output | REG_W | Micro-op first source |
| out_src_b | output | REG_W | Micro-op second source |
| out_off | output | OFF_W | Micro-op offset |
| out_last | output | 1 | Final micro-op of its expansion |

## Verification
The two functions that can fall in one cycle are the second micro-op of a compare-branch leaving the output and the next instruction entering the input. This happens because `in_ready` rises as the tail op drains. The bench provokes it by holding a further instruction valid during a pair, with `out_ready` high. It checks that `in_ready` stays low while the compare op is shown, that the following cycle issues the branch and accepts the waiting instruction together, and that that instruction's op appears only after the branch. Back-pressure patterns in the vector table also stall the output in the middle of a pair, which tests hold-stability and ordering at the same time.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 4'd0,
      OPC_NOR  = 4'd1,
      OPC_SLT  = 4'd2,
      OPC_BEQ  = 4'd3,
      OPC_BNE  = 4'd4,
      OPC_SUB  = 4'd5,
      OPC_AND  = 4'd6,
      OPC_OR   = 4'd7,
      OPC_COPY = 4'd8,
      OPC_INV  = 4'd9,
      OPC_JMP  = 4'd10,
      OPC_BGT  = 4'd11,
      OPC_BLT  = 4'd12,
      OPC_BGE  = 4'd13,
      OPC_BLE  = 4'd14,
      OPC_RSV  = 4'd15
   } opc_e;

   typedef enum logic [1:0] {
      K_PASS  = 2'd0,
      K_ALU0  = 2'd1,
      K_JUMP  = 2'd2,
      K_CMPBR = 2'd3
   } kind_e;

endpackage

// File: rtl/pxp_classify.sv
module pxp_classify
   import pxp_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output kind_e            kind,
   output logic [OPC_W-1:0] alu_opc,
   output logic             swap_ab,
   output logic             use_bne
);

   always_comb begin
      kind    = K_PASS;
      alu_opc = OPC_ADD;
      swap_ab = 1'b0;
      use_bne = 1'b0;
      case (opc)
         OPC_COPY: begin
            kind    = K_ALU0;
            alu_opc = OPC_ADD;
         end
         OPC_INV: begin
            kind    = K_ALU0;
            alu_opc = OPC_NOR;
         end
         OPC_JMP: begin
            kind = K_JUMP;
         end
         OPC_BGT: begin
            kind    = K_CMPBR;
            swap_ab = 1'b1;
            use_bne = 1'b1;
         end
         OPC_BLT: begin
            kind    = K_CMPBR;
            use_bne = 1'b1;
         end
         OPC_BGE: begin
            kind = K_CMPBR;
         end
         OPC_BLE: begin
            kind    = K_CMPBR;
            swap_ab = 1'b1;
         end
         default: begin
            kind = K_PASS;
         end
      endcase
   end

endmodule

// File: rtl/pxp_expand.sv
module pxp_expand
   import pxp_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int OFF_W   = 16,
   parameter int TMP_REG = 1,
   localparam int UW     = OPC_W + 3*REG_W + OFF_W + 1
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [REG_W-1:0] rd,
   input  logic [REG_W-1:0] rs,
   input  logic [REG_W-1:0] rt,
   input  logic [OFF_W-1:0] off,
   input  kind_e            kind,
   input  logic [OPC_W-1:0] alu_opc,
   input  logic             swap_ab,
   input  logic             use_bne,
   output logic [UW-1:0]    uop_first,
   output logic [UW-1:0]    uop_second,
   output logic             two_ops
);

   localparam logic [REG_W-1:0] ZR = '0;
   localparam logic [REG_W-1:0] TR = REG_W'(TMP_REG);
   localparam logic [OFF_W-1:0] NO_OFF = '0;

   logic [REG_W-1:0] cmp_a, cmp_b;
   logic [OPC_W-1:0] br_opc;

   assign cmp_a  = swap_ab ? rt : rs;
   assign cmp_b  = swap_ab ? rs : rt;
   assign br_opc = use_bne ? OPC_BNE : OPC_BEQ;

   always_comb begin
      uop_second = '0;
      two_ops    = 1'b0;
      case (kind)
         K_ALU0:  uop_first = {alu_opc, rd, rs, ZR, NO_OFF, 1'b1};
         K_JUMP:  uop_first = {OPC_BEQ, ZR, ZR, ZR, off, 1'b1};
         K_CMPBR: begin
            uop_first  = {OPC_SLT, TR, cmp_a, cmp_b, NO_OFF, 1'b0};
            uop_second = {br_opc, ZR, TR, ZR, off, 1'b1};
            two_ops    = 1'b1;
         end
         default: uop_first = {opc, rd, rs, rt, off, 1'b1};
      endcase
   end

endmodule

// File: rtl/pxp_issue.sv
module pxp_issue #(
   parameter int UW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [UW-1:0] in_first,
   input  logic [UW-1:0] in_second,
   input  logic          in_two,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [UW-1:0] out_uop
);

   logic          head_v, tail_v;
   logic [UW-1:0] head_q, tail_q;
   logic          take_in, give_out;

   assign in_ready  = !tail_v && (!head_v || out_ready);
   assign take_in   = in_valid && in_ready;
   assign give_out  = head_v && out_ready;
   assign out_valid = head_v;
   assign out_uop   = head_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_v <= 1'b0;
         tail_v <= 1'b0;
         head_q <= '0;
         tail_q <= '0;
      end else if (take_in) begin
         head_v <= 1'b1;
         head_q <= in_first;
         tail_v <= in_two;
         tail_q <= in_second;
      end else if (give_out) begin
         if (tail_v) begin
            head_q <= tail_q;
            tail_v <= 1'b0;
         end else begin
            head_v <= 1'b0;
         end
      end
   end

   // R11: one register between acceptance and the output
   p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R10: a stalled micro-op does not change
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_uop)));

endmodule

// File: rtl/pxp_expander.sv
module pxp_expander
   import pxp_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int OFF_W   = 16,
   parameter int TMP_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OPC_W-1:0] in_opc,
   input  logic [REG_W-1:0] in_rd,
   input  logic [REG_W-1:0] in_rs,
   input  logic [REG_W-1:0] in_rt,
   input  logic [OFF_W-1:0] in_off,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OPC_W-1:0] out_opc,
   output logic [REG_W-1:0] out_dst,
   output logic [REG_W-1:0] out_src_a,
   output logic [REG_W-1:0] out_src_b,
   output logic [OFF_W-1:0] out_off,
   output logic             out_last
);

   localparam int UW = OPC_W + 3*REG_W + OFF_W + 1;
   localparam logic [REG_W-1:0] TR = REG_W'(TMP_REG);

   generate
      if (REG_W < 2) begin : g_bad_reg_w
         $error("pxp_expander: REG_W must be at least 2");
      end
      if (OFF_W < 1) begin : g_bad_off_w
         $error("pxp_expander: OFF_W must be at least 1");
      end
      if (TMP_REG == 0 || TMP_REG >= (1 << REG_W)) begin : g_bad_tmp
         $error("pxp_expander: TMP_REG must be nonzero and addressable");
      end
   endgenerate

   kind_e            kind;
   logic [OPC_W-1:0] alu_opc;
   logic             swap_ab, use_bne, two_ops;
   logic [UW-1:0]    uop_first, uop_second, uop_out;

   pxp_classify u_classify (
      .opc     (in_opc),
      .kind    (kind),
      .alu_opc (alu_opc),
      .swap_ab (swap_ab),
      .use_bne (use_bne)
   );

   pxp_expand #(
      .REG_W   (REG_W),
      .OFF_W   (OFF_W),
      .TMP_REG (TMP_REG)
   ) u_expand (
      .opc        (in_opc),
      .rd         (in_rd),
      .rs         (in_rs),
      .rt         (in_rt),
      .off        (in_off),
      .kind       (kind),
      .alu_opc    (alu_opc),
      .swap_ab    (swap_ab),
      .use_bne    (use_bne),
      .uop_first  (uop_first),
      .uop_second (uop_second),
      .two_ops    (two_ops)
   );

   pxp_issue #(
      .UW (UW)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_first  (uop_first),
      .in_second (uop_second),
      .in_two    (two_ops),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_uop   (uop_out)
   );

   assign {out_opc, out_dst, out_src_a, out_src_b, out_off, out_last} = uop_out;

   // R9: no new instruction while a pair is half issued
   p_pair_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);

   // R9: the branch op follows its compare op directly
   p_pair_adjacent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (out_valid && out_last && out_src_a == TR));

   // R8: only the branch op of a pair carries an offset
   p_pair_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_off == '0));

   // R6 and R7: the first op of a pair writes the scratch register via SLT
   p_pair_slt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_opc == OPC_SLT && out_dst == TR));

endmodule

// File: tb/pxp_expander_tb.sv
module pxp_expander_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 14;
   localparam int VW = 4 + 4 + 15 + 16;

   // {ready pattern, opcode, rd, rs, rt, offset}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {4'hF, 4'd0,  5'd3,  5'd4,  5'd5,  16'h1234},
      {4'hF, 4'd2,  5'd6,  5'd7,  5'd8,  16'h0001},
      {4'h5, 4'd4,  5'd0,  5'd7,  5'd8,  16'hFFF0},
      {4'hF, 4'd15, 5'd17, 5'd18, 5'd19, 16'hA5A5},
      {4'hF, 4'd8,  5'd9,  5'd10, 5'd11, 16'hBEEF},
      {4'hA, 4'd9,  5'd31, 5'd30, 5'd2,  16'h0055},
      {4'hF, 4'd10, 5'd5,  5'd6,  5'd7,  16'h8000},
      {4'hF, 4'd11, 5'd4,  5'd12, 5'd13, 16'h0010},
      {4'h6, 4'd12, 5'd4,  5'd12, 5'd13, 16'h0020},
      {4'hF, 4'd13, 5'd4,  5'd20, 5'd21, 16'hFFFC},
      {4'h9, 4'd14, 5'd4,  5'd20, 5'd21, 16'h7FFF},
      {4'h3, 4'd11, 5'd0,  5'd0,  5'd31, 16'h0100},
      {4'hC, 4'd14, 5'd0,  5'd31, 5'd31, 16'h0200},
      {4'h1, 4'd8,  5'd0,  5'd0,  5'd0,  16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_opc = '0;
   logic [4:0]  in_rd = '0, in_rs = '0, in_rt = '0;
   logic [15:0] in_off = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [3:0]  out_opc;
   logic [4:0]  out_dst, out_src_a, out_src_b;
   logic [15:0] out_off;
   logic        out_last;

   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxp_expander u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready),
      .in_opc (in_opc), .in_rd (in_rd), .in_rs (in_rs), .in_rt (in_rt), .in_off (in_off),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_opc (out_opc), .out_dst (out_dst), .out_src_a (out_src_a), .out_src_b (out_src_b),
      .out_off (out_off), .out_last (out_last)
   );

   function automatic logic [35:0] seen();
      return {out_opc, out_dst, out_src_a, out_src_b, out_off, out_last};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd8:         return "R3";
         4'd9:         return "R4";
         4'd10:        return "R5";
         4'd11, 4'd12: return "R6";
         4'd13, 4'd14: return "R7";
         default:      return "R2";
      endcase
   endfunction

   // Expected expansion, written from the requirements
   task automatic model(input logic [3:0] op, input logic [4:0] rd, input logic [4:0] rs,
                        input logic [4:0] rt, input logic [15:0] off,
                        output int n, output logic [35:0] e0, output logic [35:0] e1);
      n  = 1;
      e1 = '0;
      case (op)
         4'd8:  e0 = {4'd0, rd, rs, 5'd0, 16'd0, 1'b1};
         4'd9:  e0 = {4'd1, rd, rs, 5'd0, 16'd0, 1'b1};
         4'd10: e0 = {4'd3, 5'd0, 5'd0, 5'd0, off, 1'b1};
         4'd11: begin n = 2; e0 = {4'd2, 5'd1, rt, rs, 16'd0, 1'b0}; e1 = {4'd4, 5'd0, 5'd1, 5'd0, off, 1'b1}; end
         4'd12: begin n = 2; e0 = {4'd2, 5'd1, rs, rt, 16'd0, 1'b0}; e1 = {4'd4, 5'd0, 5'd1, 5'd0, off, 1'b1}; end
         4'd13: begin n = 2; e0 = {4'd2, 5'd1, rs, rt, 16'd0, 1'b0}; e1 = {4'd3, 5'd0, 5'd1, 5'd0, off, 1'b1}; end
         4'd14: begin n = 2; e0 = {4'd2, 5'd1, rt, rs, 16'd0, 1'b0}; e1 = {4'd3, 5'd0, 5'd1, 5'd0, off, 1'b1}; end
         default: e0 = {op, rd, rs, rt, off, 1'b1};
      endcase
   endtask

   // Called right after a negedge
   task automatic run_vec(input logic [VW-1:0] v);
      logic [3:0]  pat, op;
      logic [4:0]  rd, rs, rt;
      logic [15:0] off;
      logic [35:0] e [2];
      logic [35:0] held;
      logic        stalled;
      int n, got, cyc;
      {pat, op, rd, rs, rt, off} = v;
      model(op, rd, rs, rt, off, n, e[0], e[1]);
      in_valid = 1'b1; in_opc = op; in_rd = rd; in_rs = rs; in_rt = rt; in_off = off;
      out_ready = 1'b0;
      #1;
      chk(in_ready, "R1 idle in_ready", 64'(in_ready), 64'd1);
      @(negedge clk);
      in_valid = 1'b0; in_opc = 4'd7; in_rd = 5'd29; in_rs = 5'd28; in_rt = 5'd27; in_off = 16'h5A5A;
      got = 0; cyc = 0; stalled = 1'b0; held = '0;
      while (got < n && cyc < 20) begin
         out_ready = pat[cyc % 4];
         #1;
         if (cyc == 0) chk(out_valid, "R11 first op next cycle", 64'(out_valid), 64'd1);
         if (stalled) chk(out_valid && seen() == held, "R10 hold under stall", 64'(seen()), 64'(held));
         stalled = 1'b0;
         if (out_valid) begin
            if (n == 2 && got == 0) begin
               chk(!in_ready, "R9 input blocked mid pair", 64'(in_ready), 64'd0);
               chk(out_last == 1'b0 && out_off == 16'd0, "R8 first op flags", 64'({out_last, out_off}), 64'd0);
            end
            if (out_ready) begin
               chk(seen() == e[got], req_of(op), 64'(seen()), 64'(e[got]));
               if (n == 2 && got == 1)
                  chk(out_last && out_off == off, "R8 branch op flags", 64'({out_last, out_off}), 64'({1'b1, off}));
               got++;
            end else begin
               stalled = 1'b1;
               held = seen();
            end
         end
         @(negedge clk);
         cyc++;
      end
      out_ready = 1'b0;
      #1;
      chk(got == n, "R9 op count", 64'(got), 64'(n));
      chk(!out_valid && in_ready, "R9 drained after expansion", 64'({out_valid, in_ready}), 64'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [35:0] ex;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      chk(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'd1);
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R9: next instruction waits behind a pair, then enters as the branch leaves
      @(negedge clk);
      in_valid = 1'b1; in_opc = 4'd12; in_rd = 5'd0; in_rs = 5'd14; in_rt = 5'd15; in_off = 16'h0040;
      out_ready = 1'b1;
      @(negedge clk);
      in_opc = 4'd8; in_rd = 5'd22; in_rs = 5'd23; in_rt = 5'd24; in_off = 16'h9999;
      #1;
      ex = {4'd2, 5'd1, 5'd14, 5'd15, 16'd0, 1'b0};
      chk(out_valid && seen() == ex, "R6 pair compare op", 64'(seen()), 64'(ex));
      chk(!in_ready, "R9 waiting instruction blocked", 64'(in_ready), 64'd0);
      @(negedge clk);
      #1;
      ex = {4'd4, 5'd0, 5'd1, 5'd0, 16'h0040, 1'b1};
      chk(out_valid && seen() == ex, "R9 branch op next", 64'(seen()), 64'(ex));
      chk(in_ready, "R9 accept alongside tail", 64'(in_ready), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      ex = {4'd0, 5'd22, 5'd23, 5'd0, 16'd0, 1'b1};
      chk(out_valid && seen() == ex, "R3 waiting copy after pair", 64'(seen()), 64'(ex));
      @(negedge clk);
      #1;
      chk(!out_valid, "R9 empty after burst", 64'(out_valid), 64'd0);

      // R1: reset in the middle of a pair clears the output
      @(negedge clk);
      in_valid = 1'b1; in_opc = 4'd11; in_rs = 5'd3; in_rt = 5'd4; in_off = 16'h0008;
      out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!out_valid && in_ready, "R1 reset mid pair", 64'({out_valid, in_ready}), 64'b01);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule